// File: doc/BRIEF.md
# Reversible Quadrature Step Generator

This block drives a two-phase output pair the way an incremental position encoder does. Each step changes exactly one of the two phases. The order of the changes tells a receiver which way the emulated shaft is turning. A programmable clock divider sets the time between steps. A run input starts and freezes the stream, and a direction input may be flipped at any moment. The pair continues from wherever it stands, with no return to a home state.

A step counter lets a controller ask for a fixed number of steps. The controller loads the counter with the number of steps minus one. A sticky completion flag rises on the step that makes the counter pass zero. Stepping itself goes on until run is dropped, so the controller decides whether to stop or reload. The next phase state is formed with bit operations: the two phase bits are exchanged and one of them is inverted, the direction choosing which one.

Top module: `quad_stepgen`

## Requirements
- R1: While reset is held and after it is released, phase_a and phase_b are 0, step_pulse is 0 and cnt_done is 0.
- R2: With dir_rev = 0, successive steps move {phase_a, phase_b} through 00, 10, 11, 01 and back to 00.
- R3: With dir_rev = 1, successive steps move {phase_a, phase_b} through 00, 01, 11, 10 and back to 00.
- R4: No step changes both phases at once, including a step taken just after dir_rev has changed.
- R5: While run_en stays high and rate_div is held, steps are rate_div+1 clock cycles apart, and the first step comes rate_div+1 cycles after run_en rises. step_pulse is high for exactly the cycles in which the phases show a new step.
- R6: A change of rate_div during a step period does not shorten or lengthen that period. The new value sets the period that follows the next step.
- R7: While run_en is low, the phases hold their value and step_pulse stays 0.
- R8: After a cnt_load pulse carrying value N, cnt_done rises together with step number N+1 and then stays high until the next cnt_load, which clears it.
- R9: A counter that has not been loaded since reset, or that has already signalled, never raises cnt_done. A cnt_load in the same cycle as a step takes priority, so that step is not counted.
- R10: A change of dir_rev between two steps makes the next step leave the current state in the new direction, without passing through 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High to step, low to freeze the phases |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| rate_div | input | DIV_W | Step period minus one, in clock cycles |
| cnt_load | input | 1 | Loads the step counter and arms the flag |
| cnt_init | input | CNT_W | Number of steps minus one |
| phase_a | output | 1 | Leading phase in the forward direction |
| phase_b | output | 1 | Trailing phase in the forward direction |
| step_pulse | output | 1 | High in each cycle that shows a new step |
| cnt_done | output | 1 | Sticky completion flag |

## Verification
The assertions assume that reset is held low before the first clock edge. They also assume that every input is settled at each rising edge, so dir_rev and run_en can be treated as sampled once per cycle. They do not restrict how the inputs change. The stimulus changes all inputs half a cycle away from the active edge. It keeps run_en low for at least one cycle after each reset, so the first period always uses a latched rate. The random section mixes short and zero-length periods, toggles direction in the middle of runs, and issues loads on step cycles and between them.

// File: rtl/qsg_pkg.sv
package qsg_pkg;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_REV = 1'b1
   } qsg_dir_e;

   // bit 1 = phase A, bit 0 = phase B
   typedef logic [1:0] qsg_phase_t;

   localparam qsg_phase_t PHASE_HOME = 2'b00;

   // exchange the bits, invert A going forward or B going back
   function automatic qsg_phase_t qsg_next_bitwise(qsg_phase_t cur, qsg_dir_e dir);
      qsg_phase_t swapped;
      swapped = {cur[0], cur[1]};
      return (dir == DIR_FWD) ? (swapped ^ 2'b10) : (swapped ^ 2'b01);
   endfunction

   // same mapping written as an explicit state table
   function automatic qsg_phase_t qsg_next_table(qsg_phase_t cur, qsg_dir_e dir);
      qsg_phase_t nxt;
      unique case ({dir, cur})
         3'b0_00: nxt = 2'b10;
         3'b0_10: nxt = 2'b11;
         3'b0_11: nxt = 2'b01;
         3'b0_01: nxt = 2'b00;
         3'b1_00: nxt = 2'b01;
         3'b1_01: nxt = 2'b11;
         3'b1_11: nxt = 2'b10;
         default: nxt = 2'b00;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/qsg_rate_div.sv
module qsg_rate_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [DIV_W-1:0] rate_div,
   output logic             tick
);

   localparam logic [DIV_W-1:0] CNT_ZERO = '0;
   localparam logic [DIV_W-1:0] CNT_ONE  = {{(DIV_W-1){1'b0}}, 1'b1};

   logic [DIV_W-1:0] elapsed_q;
   logic [DIV_W-1:0] reload_q;

   assign tick = run_en && (elapsed_q == reload_q);

   // the reload value is captured only at a step boundary or while frozen
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed_q <= CNT_ZERO;
         reload_q  <= CNT_ZERO;
      end else if (!run_en) begin
         elapsed_q <= CNT_ZERO;
         reload_q  <= rate_div;
      end else if (tick) begin
         elapsed_q <= CNT_ZERO;
         reload_q  <= rate_div;
      end else begin
         elapsed_q <= elapsed_q + CNT_ONE;
      end
   end

endmodule

// File: rtl/qsg_phase_seq.sv
module qsg_phase_seq
   import qsg_pkg::*;
#(
   parameter bit USE_TABLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic dir_rev,
   output logic phase_a,
   output logic phase_b,
   output logic step_pulse
);

   qsg_phase_t state_q;
   qsg_phase_t state_nxt;
   qsg_dir_e   dir;
   logic       pulse_q;

   assign dir = qsg_dir_e'(dir_rev);

   generate
      if (USE_TABLE) begin : g_table
         always_comb state_nxt = qsg_next_table(state_q, dir);
      end else begin : g_bitwise
         always_comb state_nxt = qsg_next_bitwise(state_q, dir);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PHASE_HOME;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= tick;
         if (tick) begin
            state_q <= state_nxt;
         end
      end
   end

   assign phase_a    = state_q[1];
   assign phase_b    = state_q[0];
   assign step_pulse = pulse_q;

endmodule

// File: rtl/qsg_step_cnt.sv
module qsg_step_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_init,
   output logic             cnt_done
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CNT_WRAP = '1;

   logic [CNT_W-1:0] remain_q;
   logic             armed_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= CNT_ZERO;
         armed_q  <= 1'b0;
         done_q   <= 1'b0;
      end else if (cnt_load) begin
         remain_q <= cnt_init;
         armed_q  <= 1'b1;
         done_q   <= 1'b0;
      end else if (tick) begin
         if (remain_q == CNT_ZERO) begin
            remain_q <= CNT_WRAP;
            if (armed_q) begin
               done_q  <= 1'b1;
               armed_q <= 1'b0;
            end
         end else begin
            remain_q <= remain_q - CNT_ONE;
         end
      end
   end

   assign cnt_done = done_q;

endmodule

// File: rtl/quad_stepgen.sv
module quad_stepgen #(
   parameter int DIV_W     = 16,
   parameter int CNT_W     = 16,
   parameter bit USE_TABLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             dir_rev,
   input  logic [DIV_W-1:0] rate_div,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_init,
   output logic             phase_a,
   output logic             phase_b,
   output logic             step_pulse,
   output logic             cnt_done
);

   generate
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("quad_stepgen: DIV_W must lie in 1..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("quad_stepgen: CNT_W must lie in 1..32");
      end
   endgenerate

   logic step_tick;

   qsg_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .rate_div(rate_div),
      .tick    (step_tick)
   );

   qsg_phase_seq #(.USE_TABLE(USE_TABLE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (step_tick),
      .dir_rev   (dir_rev),
      .phase_a   (phase_a),
      .phase_b   (phase_b),
      .step_pulse(step_pulse)
   );

   qsg_step_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (step_tick),
      .cnt_load(cnt_load),
      .cnt_init(cnt_init),
      .cnt_done(cnt_done)
   );

endmodule

// File: rtl/qsg_checker.sv
module qsg_checker (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic dir_rev,
   input logic cnt_load,
   input logic tick,
   input logic phase_a,
   input logic phase_b,
   input logic step_pulse,
   input logic cnt_done
);

   // R4: at most one phase moves per cycle
   assert_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({phase_a, phase_b} ^ $past({phase_a, phase_b})) <= 1);

   // R2: a forward step advances A first
   assert_fwd_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !dir_rev) |=> ({phase_a, phase_b} == {~$past(phase_b), $past(phase_a)}));

   // R3: a reverse step advances B first
   assert_rev_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && dir_rev) |=> ({phase_a, phase_b} == {$past(phase_b), ~$past(phase_a)}));

   // R7: frozen while run is low
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ($stable({phase_a, phase_b}) && !step_pulse));

   // R5: phases move only with the strobe
   assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ({phase_a, phase_b} != $past({phase_a, phase_b})) |-> step_pulse);

   // R8: a load clears the flag
   assert_load_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> !cnt_done);

   // R9: the flag rises only on a counted step
   assert_done_on_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_done) |-> ($past(tick) && !$past(cnt_load)));

endmodule

bind quad_stepgen qsg_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .dir_rev   (dir_rev),
   .cnt_load  (cnt_load),
   .tick      (step_tick),
   .phase_a   (phase_a),
   .phase_b   (phase_b),
   .step_pulse(step_pulse),
   .cnt_done  (cnt_done)
);

// File: tb/sim_quad_stepgen.sv
module sim_quad_stepgen;

   localparam int DIV_W = 16;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             run_en = 1'b0;
   logic             dir_rev = 1'b0;
   logic [DIV_W-1:0] rate_div = '0;
   logic             cnt_load = 1'b0;
   logic [CNT_W-1:0] cnt_init = '0;
   logic             phase_a, phase_b, step_pulse, cnt_done;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   quad_stepgen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .dir_rev(dir_rev),
      .rate_div(rate_div), .cnt_load(cnt_load), .cnt_init(cnt_init),
      .phase_a(phase_a), .phase_b(phase_b), .step_pulse(step_pulse),
      .cnt_done(cnt_done)
   );

   // reference behaviour built from the requirements
   logic [DIV_W-1:0] m_el, m_rl;
   logic [CNT_W-1:0] m_rem;
   logic [1:0]       m_ph;
   logic             m_pulse, m_armed, m_done;

   function automatic logic [1:0] exp_next(logic [1:0] p, logic rev);
      if (!rev) return {~p[0], p[1]};
      return {p[0], ~p[1]};
   endfunction

   always @(posedge clk) begin
      logic tk;
      tk = run_en && (m_el == m_rl);
      if (!rst_n) begin
         m_el <= '0; m_rl <= '0; m_ph <= 2'b00; m_pulse <= 1'b0;
         m_rem <= '0; m_armed <= 1'b0; m_done <= 1'b0;
      end else begin
         if (!run_en || tk) begin m_el <= '0; m_rl <= rate_div; end
         else m_el <= m_el + 1'b1;
         m_pulse <= tk;
         if (tk) m_ph <= exp_next(m_ph, dir_rev);
         if (cnt_load) begin m_rem <= cnt_init; m_armed <= 1'b1; m_done <= 1'b0; end
         else if (tk) begin
            if (m_rem == '0) begin
               m_rem <= '1;
               if (m_armed) begin m_done <= 1'b1; m_armed <= 1'b0; end
            end else m_rem <= m_rem - 1'b1;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!step_pulse && n < 100);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; run_en = 1'b0; cnt_load = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      int n;
      logic [1:0] fwd_seq [4];
      logic [1:0] rev_seq [4];
      fwd_seq = '{2'b10, 2'b11, 2'b01, 2'b00};
      rev_seq = '{2'b01, 2'b11, 2'b10, 2'b00};
      void'($urandom(32'd5150));

      // R1
      repeat (2) @(negedge clk);
      check("R1 phases in reset", {phase_a, phase_b}, 0);
      do_reset();
      check("R1 phases after reset", {phase_a, phase_b}, 0);
      check("R1 pulse after reset", step_pulse, 0);
      check("R1 done after reset", cnt_done, 0);

      // R2 forward at full rate
      rate_div = '0; dir_rev = 1'b0; run_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R2 forward state", {phase_a, phase_b}, fwd_seq[i]);
         check("R5 pulse with step", step_pulse, 1);
      end
      // R3 reverse
      dir_rev = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R3 reverse state", {phase_a, phase_b}, rev_seq[i]);
      end
      // R10 reversal from a mid state
      dir_rev = 1'b0; @(negedge clk);
      dir_rev = 1'b0; @(negedge clk);
      check("R10 before reversal", {phase_a, phase_b}, 2'b11);
      dir_rev = 1'b1; @(negedge clk);
      check("R10 after reversal", {phase_a, phase_b}, 2'b10);

      // R7 hold
      run_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R7 hold state", {phase_a, phase_b}, 2'b10);
         check("R7 no pulse", step_pulse, 0);
      end

      // R5 period
      rate_div = 16'd3; @(negedge clk);
      run_en = 1'b1;
      wait_pulse(n); check("R5 first step delay", n, 4);
      wait_pulse(n); check("R5 step spacing", n, 4);

      // R6 rate change mid period
      rate_div = 16'd4;
      wait_pulse(n); check("R6 old rate kept", n, 4);
      repeat (2) @(negedge clk);
      rate_div = 16'd1;
      wait_pulse(n); check("R6 old rate mid change", n, 3);
      wait_pulse(n); check("R6 new rate applied", n, 2);

      // R8 terminal flag
      run_en = 1'b0; rate_div = '0;
      cnt_load = 1'b1; cnt_init = 16'd2; @(negedge clk);
      cnt_load = 1'b0; run_en = 1'b1;
      @(negedge clk); check("R8 done after step 1", cnt_done, 0);
      @(negedge clk); check("R8 done after step 2", cnt_done, 0);
      @(negedge clk); check("R8 done after step 3", cnt_done, 1);
      repeat (20) @(negedge clk);
      check("R8 done sticky", cnt_done, 1);
      // R9 no second rise without load: still set, then reload clears
      cnt_load = 1'b1; cnt_init = 16'd40; @(negedge clk);
      cnt_load = 1'b0;
      check("R8 load clears", cnt_done, 0);

      // R9 unarmed counter
      do_reset();
      rate_div = '0; run_en = 1'b1;
      repeat (8) @(negedge clk);
      check("R9 unarmed no flag", cnt_done, 0);
      // R9 load wins over a simultaneous step
      cnt_load = 1'b1; cnt_init = '0; @(negedge clk);
      cnt_load = 1'b0;
      check("R9 load cycle no flag", cnt_done, 0);
      @(negedge clk);
      check("R9 first counted step", cnt_done, 1);

      // random section against the reference
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 40) == 0) run_en = ~run_en;
         if (($urandom % 9) == 0)  dir_rev = ~dir_rev;
         if (($urandom % 25) == 0) rate_div = 16'($urandom % 4);
         cnt_load = (($urandom % 60) == 0);
         cnt_init = 16'($urandom % 12);
         @(negedge clk);
         check(dir_rev ? "R3 random phases" : "R2 random phases",
               {phase_a, phase_b}, m_ph);
         check("R5 random pulse", step_pulse, m_pulse);
         check("R8 random flag", cnt_done, m_done);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule